// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-line priority interrupt controllers into one sixteen-line unit. Lines 0 to 7 go to the upper (master) controller and lines 8 to 15 go to the lower (slave) controller. The slave's pending request is fed into master line 2. The processor sees a single interrupt wire. Each line is edge-captured, can be masked, and is held in service from acknowledge until the processor issues an end-of-interrupt to the controller that owns it. Lower line numbers win.

The processor answers the interrupt wire with a one-cycle acknowledge strobe. The block then works out which controller supplies the winner. It returns a one-cycle result that carries the sixteen-line request number and an eight-bit vector, built from that controller's vector base and the line number. An optional nesting mode on the master lets a more urgent slave line interrupt a slave handler that is already running. Each controller also has one edge/level control byte, and writes to it pass through a fixed mask. The stored byte is only reported on the outputs and does not change how requests are captured.

Top module: `cascade_intc_pair`

## Requirements
- R1: A rising edge on `irq_in[i]` latches a request for line i. A line held high raises no further request after its request has been serviced.
- R2: A masked line (mask bit 1) does not assert `cpu_irq`. Its latched request is kept, and it asserts `cpu_irq` once it is unmasked.
- R3: `cpu_irq` is a register that follows the master's request decision, exactly one clock later.
- R4: Lower line numbers have higher priority. A line in service blocks lines of equal or lower priority on the same controller until its end-of-interrupt. A higher-priority line still interrupts.
- R5: For an acknowledge won by master line L (L not 2), the result cycle gives `ack_irq` = L and `ack_vector` = {`vbase_m`, L[2:0]}. `ack_valid` is high only in the cycle after `ack`.
- R6: The slave's request sets master line 2, and `irq_in[2]` is ignored. When master line 2 wins, the slave acknowledges its own winner S. The result is then `ack_irq` = 8+S and `ack_vector` = {`vbase_s`, S[2:0]}.
- R7: An acknowledge with no master winner reports line 7 ({`vbase_m`,3'd7}) and changes no state. If master line 2 wins but the slave has no unmasked winner, the block reports 15 ({`vbase_s`,3'd7}).
- R8: With `nested_en` low, a slave line in service blocks every other slave line. With it high, the master leaves line 2 out of its in-service check, so a higher-priority slave line interrupts.
- R9: `eoi_m` / `eoi_s` clears the highest-priority in-service bit of that controller. The in-service state changes only on an acknowledge or an end-of-interrupt.
- R10: A write with `ctl_sel`=0 stores `ctl_wdata & 8'hF8` in `ctl_m`. A write with `ctl_sel`=1 stores `ctl_wdata & 8'hDE` in `ctl_s`. Both bytes reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines; bit 2 unused (cascade) |
| mask_m | input | 8 | Master line masks |
| mask_s | input | 8 | Slave line masks |
| vbase_m | input | 5 | Master vector base, vector bits 7:3 |
| vbase_s | input | 5 | Slave vector base, vector bits 7:3 |
| nested_en | input | 1 | Master nesting mode for slave lines |
| ack | input | 1 | Processor acknowledge strobe |
| eoi_m | input | 1 | End-of-interrupt to master |
| eoi_s | input | 1 | End-of-interrupt to slave |
| ctl_we | input | 1 | Control byte write enable |
| ctl_sel | input | 1 | 0 master, 1 slave control byte |
| ctl_wdata | input | 8 | Control byte write data |
| cpu_irq | output | 1 | Interrupt to processor |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_irq | output | 4 | Acknowledged request number 0..15 |
| ack_vector | output | 8 | Acknowledged vector |
| ctl_m | output | 8 | Master control byte |
| ctl_s | output | 8 | Slave control byte |

## Verification
The assertions assume that `ack` is never high at the same time as `eoi_m` or `eoi_s`. They also assume that no line shows a new edge in the cycle its own request is acknowledged, and that the vector bases do not change while a result is pending. The stimulus keeps to this by separating acknowledges, end-of-interrupts and input pulses with idle cycles. It returns every line to low before it pulses the line again. Random rounds pulse a subset of lines together. They then drain the pending requests one acknowledge at a time, with end-of-interrupts between acknowledges, so the order is fixed purely by priority.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] line;
    } pick_t;

    // lowest-numbered set bit wins
    function automatic pick_t first_set(input logic [LINES-1:0] v);
        pick_t p;
        p = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.line  = LW'(i);
            end
        end
        return p;
    endfunction

    // rank of the winner, LINES when empty
    function automatic logic [LW:0] rank_of(input logic [LINES-1:0] v);
        pick_t p;
        p = first_set(v);
        return p.valid ? {1'b0, p.line} : (LW+1)'(LINES);
    endfunction
endpackage

// File: rtl/edge_capture.sv
`timescale 1ns/1ps
module edge_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/intc_unit.sv
`timescale 1ns/1ps
module intc_unit
    import intc_pkg::*;
#(
    parameter logic [LINES-1:0] NEST_SKIP = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] set_vec,
    input  logic [LINES-1:0] mask,
    input  logic             nested_en,
    input  logic             ack,
    input  logic             eoi,
    output logic             int_req,
    output pick_t            win,
    output logic [LINES-1:0] isr_q
);
    logic [LINES-1:0] irr_q;
    logic [LINES-1:0] busy_src;
    logic [LINES-1:0] ack_bit;
    logic [LINES-1:0] eoi_bit;
    logic [LW:0]      busy_rank;
    pick_t            eoi_pick;

    always_comb begin
        win       = first_set(irr_q & ~mask);
        busy_src  = nested_en ? (isr_q & ~NEST_SKIP) : isr_q;
        busy_rank = rank_of(busy_src);
        int_req   = win.valid && ({1'b0, win.line} < busy_rank);
        ack_bit   = (ack && int_req) ? (LINES'(1) << win.line) : '0;
        eoi_pick  = first_set(isr_q);
        eoi_bit   = (eoi && eoi_pick.valid) ? (LINES'(1) << eoi_pick.line) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
            isr_q <= '0;
        end else begin
            irr_q <= (irr_q | set_vec) & ~ack_bit;
            isr_q <= (isr_q | ack_bit) & ~eoi_bit;
        end
    end
endmodule

// File: rtl/ctl_byte.sv
`timescale 1ns/1ps
module ctl_byte #(
    parameter int          W    = 8,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata & KEEP;
    end
endmodule

// File: rtl/cascade_intc_pair.sv
`timescale 1ns/1ps
module cascade_intc_pair
    import intc_pkg::*;
#(
    parameter logic [7:0] CTL_KEEP_M = 8'hF8,
    parameter logic [7:0] CTL_KEEP_S = 8'hDE,
    parameter int         CASCADE_LINE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*LINES-1:0]   irq_in,
    input  logic [LINES-1:0]     mask_m,
    input  logic [LINES-1:0]     mask_s,
    input  logic [7-LW:0]        vbase_m,
    input  logic [7-LW:0]        vbase_s,
    input  logic                 nested_en,
    input  logic                 ack,
    input  logic                 eoi_m,
    input  logic                 eoi_s,
    input  logic                 ctl_we,
    input  logic                 ctl_sel,
    input  logic [7:0]           ctl_wdata,
    output logic                 cpu_irq,
    output logic                 ack_valid,
    output logic [LW:0]          ack_irq,
    output logic [7:0]           ack_vector,
    output logic [7:0]           ctl_m,
    output logic [7:0]           ctl_s
);
    localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE_LINE;

    logic [2*LINES-1:0] rise;
    logic [LINES-1:0]   m_set;
    logic               m_req, s_req;
    pick_t              m_win, s_win;
    logic [LINES-1:0]   m_isr, s_isr;
    logic               via_slave;
    logic [LW:0]        res_irq;
    logic [7:0]         res_vec;

    edge_capture #(.W(2*LINES)) u_edge (
        .clk(clk), .rst(rst), .lvl(irq_in), .rise(rise)
    );

    // slave pending request re-arms the cascade line every cycle
    assign m_set = (rise[LINES-1:0] & ~CASC_BIT) | (s_req ? CASC_BIT : '0);

    assign via_slave = m_req && (m_win.line == LW'(CASCADE_LINE));

    intc_unit #(.NEST_SKIP(CASC_BIT)) u_master (
        .clk(clk), .rst(rst), .set_vec(m_set), .mask(mask_m),
        .nested_en(nested_en), .ack(ack), .eoi(eoi_m),
        .int_req(m_req), .win(m_win), .isr_q(m_isr)
    );

    intc_unit #(.NEST_SKIP('0)) u_slave (
        .clk(clk), .rst(rst), .set_vec(rise[2*LINES-1:LINES]), .mask(mask_s),
        .nested_en(1'b0), .ack(ack && via_slave), .eoi(eoi_s),
        .int_req(s_req), .win(s_win), .isr_q(s_isr)
    );

    always_comb begin
        if (!m_req) begin
            res_irq = {1'b0, LW'(LINES - 1)};
            res_vec = {vbase_m, LW'(LINES - 1)};
        end else if (via_slave) begin
            res_irq = {1'b1, s_req ? s_win.line : LW'(LINES - 1)};
            res_vec = {vbase_s, s_req ? s_win.line : LW'(LINES - 1)};
        end else begin
            res_irq = {1'b0, m_win.line};
            res_vec = {vbase_m, m_win.line};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_irq    <= 1'b0;
            ack_valid  <= 1'b0;
            ack_irq    <= '0;
            ack_vector <= '0;
        end else begin
            cpu_irq   <= m_req;
            ack_valid <= ack;
            if (ack) begin
                ack_irq    <= res_irq;
                ack_vector <= res_vec;
            end
        end
    end

    ctl_byte #(.W(8), .KEEP(CTL_KEEP_M)) u_ctl_m (
        .clk(clk), .rst(rst), .we(ctl_we && !ctl_sel), .wdata(ctl_wdata), .q(ctl_m)
    );

    ctl_byte #(.W(8), .KEEP(CTL_KEEP_S)) u_ctl_s (
        .clk(clk), .rst(rst), .we(ctl_we && ctl_sel), .wdata(ctl_wdata), .q(ctl_s)
    );
endmodule

// File: rtl/intc_pair_chk.sv
`timescale 1ns/1ps
module intc_pair_chk #(
    parameter logic [7:0] KEEP_M = 8'hF8,
    parameter logic [7:0] KEEP_S = 8'hDE
) (
    input logic       clk,
    input logic       rst,
    input logic       m_req,
    input logic       cpu_irq,
    input logic       ack,
    input logic       eoi_m,
    input logic       eoi_s,
    input logic       ack_valid,
    input logic [3:0] ack_irq,
    input logic [7:0] ack_vector,
    input logic [7:0] m_isr,
    input logic [7:0] s_isr,
    input logic [7:0] ctl_m,
    input logic [7:0] ctl_s
);
    // R3
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst) m_req |=> cpu_irq);
    // R3
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst) !m_req |=> !cpu_irq);
    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) ack |=> ack_valid);
    // R5
    ack_quiet_chk: assert property (@(posedge clk) disable iff (rst) !ack |=> !ack_valid);
    // R6
    ack_line_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ack_vector[2:0] == ack_irq[2:0]));
    // R9
    m_isr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack && !eoi_m) |=> $stable(m_isr));
    // R9
    s_isr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack && !eoi_s) |=> $stable(s_isr));
    // R10
    ctl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ((ctl_m & ~KEEP_M) == 8'h00) && ((ctl_s & ~KEEP_S) == 8'h00));
endmodule

bind cascade_intc_pair intc_pair_chk #(.KEEP_M(CTL_KEEP_M), .KEEP_S(CTL_KEEP_S)) u_chk (
    .clk(clk), .rst(rst), .m_req(m_req), .cpu_irq(cpu_irq), .ack(ack),
    .eoi_m(eoi_m), .eoi_s(eoi_s), .ack_valid(ack_valid), .ack_irq(ack_irq),
    .ack_vector(ack_vector), .m_isr(m_isr), .s_isr(s_isr), .ctl_m(ctl_m), .ctl_s(ctl_s)
);

// File: tb/cascade_intc_pair_tb.sv
`timescale 1ns/1ps
module cascade_intc_pair_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] irq_in;
    logic [7:0]  mask_m, mask_s, ctl_wdata;
    logic [4:0]  vbase_m, vbase_s;
    logic        nested_en, ack, eoi_m, eoi_s, ctl_we, ctl_sel;
    logic        cpu_irq, ack_valid;
    logic [3:0]  ack_irq;
    logic [7:0]  ack_vector, ctl_m, ctl_s;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cascade_intc_pair u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .mask_m(mask_m), .mask_s(mask_s),
        .vbase_m(vbase_m), .vbase_s(vbase_s), .nested_en(nested_en), .ack(ack),
        .eoi_m(eoi_m), .eoi_s(eoi_s), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
        .ctl_wdata(ctl_wdata), .cpu_irq(cpu_irq), .ack_valid(ack_valid),
        .ack_irq(ack_irq), .ack_vector(ack_vector), .ctl_m(ctl_m), .ctl_s(ctl_s)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic [15:0] lines);
        irq_in = lines;
        tick(1);
        irq_in = '0;
    endtask

    task automatic do_ack(output int irq, output int vec);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check("R5 ack_valid", int'(ack_valid), 1);
        irq = int'(ack_irq);
        vec = int'(ack_vector);
        tick(1);
        check("R5 ack_valid one cycle", int'(ack_valid), 0);
    endtask

    task automatic do_eoi(input bit m, input bit s);
        eoi_m = m;
        eoi_s = s;
        tick(1);
        eoi_m = 1'b0;
        eoi_s = 1'b0;
        tick(3);
    endtask

    function automatic int exp_vec(input int irq);
        return (irq >= 8) ? (int'(vbase_s) * 8 + irq - 8) : (int'(vbase_m) * 8 + irq);
    endfunction

    // next winner by priority with the slave folded into master line 2
    function automatic int next_winner(input logic [15:0] pend);
        logic [7:0] m;
        m = pend[7:0];
        m[2] = |pend[15:8];
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                if (i == 2) begin
                    for (int j = 8; j < 16; j++) if (pend[j]) return j;
                end
                return i;
            end
        end
        return 7;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int irq, vec, seed;
        logic [15:0] pend;
        rst = 1'b1; irq_in = '0; mask_m = '0; mask_s = '0;
        vbase_m = 5'h08; vbase_s = 5'h0E; nested_en = 1'b0;
        ack = 0; eoi_m = 0; eoi_s = 0; ctl_we = 0; ctl_sel = 0; ctl_wdata = '0;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R3 reset cpu_irq", int'(cpu_irq), 0);
        check("R5 reset ack_valid", int'(ack_valid), 0);
        check("R10 reset ctl_m", int'(ctl_m), 0);
        check("R10 reset ctl_s", int'(ctl_s), 0);

        // R10 control byte masks
        ctl_we = 1; ctl_sel = 0; ctl_wdata = 8'hFF; tick(1);
        ctl_sel = 1; ctl_wdata = 8'hFF; tick(1);
        ctl_we = 0; tick(1);
        check("R10 master keep", int'(ctl_m), 8'hF8);
        check("R10 slave keep", int'(ctl_s), 8'hDE);
        ctl_we = 1; ctl_sel = 1; ctl_wdata = 8'h21; tick(1); ctl_we = 0; tick(1);
        check("R10 slave 21", int'(ctl_s), 8'h00);
        check("R10 master kept", int'(ctl_m), 8'hF8);

        // R1 R3 R5 master line 5, held high afterwards
        irq_in = 16'h0020;
        tick(1);
        check("R3 one cycle late", int'(cpu_irq), 0);
        tick(1);
        check("R3 cpu_irq up", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R5 irq", irq, 5);
        check("R5 vector", vec, exp_vec(5));
        do_eoi(1, 0);
        check("R1 held level no re-request", int'(cpu_irq), 0);
        irq_in = '0; tick(2);

        // R2 mask
        mask_m = 8'h10;
        pulse(16'h0010); tick(4);
        check("R2 masked", int'(cpu_irq), 0);
        mask_m = 8'h00; tick(3);
        check("R2 unmasked", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R2 irq", irq, 4);
        do_eoi(1, 0);

        // R6 slave line 11 and ignored irq_in[2]
        pulse(16'h0004); tick(4);
        check("R6 irq_in[2] ignored", int'(cpu_irq), 0);
        pulse(16'h0800); tick(4);
        check("R6 slave raises", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R6 irq", irq, 11);
        check("R6 vector", vec, exp_vec(11));
        do_eoi(1, 1);
        check("R6 cleared", int'(cpu_irq), 0);

        // R7 spurious master
        do_ack(irq, vec);
        check("R7 master spurious irq", irq, 7);
        check("R7 master spurious vector", vec, exp_vec(7));
        tick(2);
        check("R7 no state change", int'(cpu_irq), 0);

        // R7 spurious slave: request 9 cascades, then masked at slave
        pulse(16'h0200); tick(4);
        mask_s = 8'h02; tick(1);
        do_ack(irq, vec);
        check("R7 slave spurious irq", irq, 15);
        check("R7 slave spurious vector", vec, exp_vec(15));
        mask_s = 8'h00;
        do_eoi(1, 0);
        check("R7 slave request kept", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R7 kept irq", irq, 9);
        do_eoi(1, 1);

        // R4 R9 nesting on master
        pulse(16'h0040); tick(4);
        do_ack(irq, vec);
        check("R4 first", irq, 6);
        pulse(16'h0008); tick(4);
        check("R4 higher interrupts", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R4 nested irq", irq, 3);
        pulse(16'h0080); tick(4);
        check("R4 lower blocked", int'(cpu_irq), 0);
        do_eoi(1, 0);
        check("R9 eoi clears top only", int'(cpu_irq), 0);
        do_eoi(1, 0);
        check("R9 second eoi", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R4 last", irq, 7);
        do_eoi(1, 0);

        // R8 without nesting mode
        pulse(16'h1000); tick(4);
        do_ack(irq, vec);
        check("R8 first slave", irq, 12);
        pulse(16'h0200); tick(4);
        check("R8 blocked without nesting", int'(cpu_irq), 0);
        do_eoi(1, 1);
        check("R8 released", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R8 released irq", irq, 9);
        do_eoi(1, 1);

        // R8 with nesting mode
        nested_en = 1'b1;
        pulse(16'h1000); tick(4);
        do_ack(irq, vec);
        check("R8 nest first", irq, 12);
        pulse(16'h0200); tick(4);
        check("R8 nested passes", int'(cpu_irq), 1);
        do_ack(irq, vec);
        check("R8 nested irq", irq, 9);
        do_eoi(0, 1);
        do_eoi(1, 1);
        check("R8 all clear", int'(cpu_irq), 0);
        nested_en = 1'b0;

        // random rounds
        seed = $urandom(1234);
        for (int r = 0; r < 24; r++) begin
            pend = 16'($urandom()) & 16'hFFFB;
            if (pend == '0) pend = 16'h0001;
            pulse(pend); tick(4);
            while (pend != '0) begin
                int w;
                w = next_winner(pend);
                check("R4 random pending", int'(cpu_irq), 1);
                do_ack(irq, vec);
                check("R4 random order", irq, w);
                check("R6 random vector", vec, exp_vec(w));
                pend[w] = 1'b0;
                do_eoi(1, w >= 8);
            end
            check("R1 random drained", int'(cpu_irq), 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule